// File: doc/BRIEF.md
# Converter clock divider with tear-free result register

This block serves a successive-approximation converter and the bus that reads it. It turns the system clock into a one-cycle converter clock enable, using a 3-bit select to pick a power-of-two rate. It also holds the latest 10-bit conversion result and presents it to the bus as a low byte and a high byte. An alignment input sets where the result sits in the 16-bit word. Right alignment gives full 10-bit precision over two reads. Left alignment lets an 8-bit user read only the high byte.

The two byte reads are coupled. A strobed read of the low byte locks the visible pair, and a strobed read of the high byte releases it. A conversion that finishes while the pair is locked is parked in a shadow register. If more than one finishes, only the newest is kept. It becomes visible when the high-byte read releases the lock. A read that touches only the high byte never locks the pair. The alignment input is applied at read time, so changing it changes how the held result is presented.

Top module: `adc_clkdiv_result`

## Requirements
- R1: During and right after reset, both bytes read 0x00 and `conv_clk_en` stays low while reset is asserted.
- R2: `conv_clk_en` is a one-cycle pulse repeating every 2 cycles for select codes 0 and 1, and every 2^k cycles for code k from 2 to 7 (4, 8, 16, 32, 64, 128).
- R3: A change of `div_sel` restarts the divider. No pulse occurs in the cycle the new code first appears, and the first pulse comes exactly one division period after that cycle.
- R4: With `left_align` = 0, the high byte (`rd_hi` = 1) carries result bits 9:8 in its bits 1:0 and zero elsewhere, and the low byte (`rd_hi` = 0) carries result bits 7:0.
- R5: With `left_align` = 1, the high byte carries result bits 9:2, and the low byte carries result bits 1:0 in its bits 7:6 with bits 5:0 zero.
- R6: While the pair is unlocked, a `conv_done` strobe makes its result visible from the next cycle.
- R7: A strobed low-byte read (`rd_stb` = 1, `rd_hi` = 0) locks the pair. Later conversions do not alter either byte until a strobed high-byte read.
- R8: A strobed high-byte read does not lock the pair, so a conversion after it becomes visible at once.
- R9: A strobed high-byte read releases the lock and makes visible the newest conversion that finished during the lock. A conversion that finishes in the same cycle as the releasing read counts as the newest.
- R10: Changing `left_align` changes the layout of the currently held result without any new conversion.
- R11: A conversion that finishes in the same cycle as a strobed low-byte read does not update the pair. It is deferred like one that finishes during the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_sel | input | 3 | Converter clock division select |
| left_align | input | 1 | 1 = left-aligned result layout, 0 = right-aligned |
| conv_done | input | 1 | One-cycle strobe: conversion finished |
| conv_result | input | 10 | Conversion value, valid with `conv_done` |
| rd_stb | input | 1 | Bus byte-read strobe |
| rd_hi | input | 1 | Byte select: 1 = high byte, 0 = low byte |
| conv_clk_en | output | 1 | One-cycle converter clock enable |
| rd_data | output | 8 | Selected byte of the visible result |

## Verification
The hardest situations to reach are the collisions between the bus and the converter. One is a conversion that finishes in the exact cycle of the locking low-byte read. The other is a conversion that finishes in the exact cycle of the releasing high-byte read. Both decide whether a tear can happen. The stimulus drives `conv_done` and `rd_stb` on the same falling edge for both cases. It then reads the bytes back without a strobe, so the lock state is not disturbed, to show which value the pair holds. The divider restart is reached by stepping the select through codes in a non-monotonic order, so that every step is a real change.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

   typedef enum logic {
      BYTE_LO = 1'b0,
      BYTE_HI = 1'b1
   } byte_sel_e;

   // Division exponent for a select code, floored at a minimum exponent.
   function automatic int div_exp(input int code, input int min_exp);
      return (code < min_exp) ? min_exp : code;
   endfunction

endpackage

// File: rtl/adcr_clkdiv.sv
module adcr_clkdiv #(
   parameter int SEL_W   = 3,
   parameter int MIN_EXP = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] div_sel,
   output logic             clk_en
);
   import adcr_pkg::*;

   localparam int NCODE = 1 << SEL_W;
   localparam int CNT_W = NCODE - 1;

   if (MIN_EXP < 1) begin : g_bad_min
      $error("adcr_clkdiv: MIN_EXP must be at least 1 for a single-cycle enable");
   end
   if (MIN_EXP >= NCODE) begin : g_bad_range
      $error("adcr_clkdiv: MIN_EXP must be below the number of codes");
   end

   logic [CNT_W-1:0] lim_tab [NCODE];

   for (genvar g = 0; g < NCODE; g++) begin : g_lim
      localparam int EXP_G = div_exp(g, MIN_EXP);
      localparam int LIM_G = (1 << EXP_G) - 1;
      assign lim_tab[g] = CNT_W'(LIM_G);
   end

   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sel_chg;
   logic             hit;

   assign sel_chg = (div_sel != sel_q);
   assign hit     = (cnt_q == lim_tab[div_sel]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         cnt_q <= '0;
      end else begin
         sel_q <= div_sel;
         if (sel_chg || hit) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign clk_en = hit & ~sel_chg;

endmodule

// File: rtl/adcr_result_store.sv
module adcr_result_store #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_result,
   input  logic             rd_stb,
   input  logic             rd_hi,
   output logic [RES_W-1:0] vis_q,
   output logic             lock_q
);
   import adcr_pkg::*;

   logic [RES_W-1:0] shadow_q;
   logic             pend_q;
   byte_sel_e        bsel;
   logic             release_now;
   logic             lock_now;

   assign bsel        = byte_sel_e'(rd_hi);
   assign release_now = rd_stb && (bsel == BYTE_HI);
   assign lock_now    = lock_q || (rd_stb && (bsel == BYTE_LO));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vis_q    <= '0;
         shadow_q <= '0;
         pend_q   <= 1'b0;
         lock_q   <= 1'b0;
      end else if (release_now) begin
         lock_q <= 1'b0;
         pend_q <= 1'b0;
         if (conv_done) begin
            vis_q <= conv_result;
         end else if (pend_q) begin
            vis_q <= shadow_q;
         end
      end else if (lock_now) begin
         lock_q <= 1'b1;
         if (conv_done) begin
            shadow_q <= conv_result;
            pend_q   <= 1'b1;
         end
      end else if (conv_done) begin
         vis_q <= conv_result;
      end
   end

endmodule

// File: rtl/adcr_byte_format.sv
module adcr_byte_format #(
   parameter int RES_W  = 10,
   parameter int BYTE_W = 8
) (
   input  logic [RES_W-1:0]  vis,
   input  logic              left_align,
   input  logic              rd_hi,
   output logic [BYTE_W-1:0] rd_data
);
   import adcr_pkg::*;

   localparam int WORD_W = 2 * BYTE_W;
   localparam int PAD_W  = WORD_W - RES_W;

   logic [WORD_W-1:0] word_r;
   logic [WORD_W-1:0] word_l;
   logic [WORD_W-1:0] word;
   byte_sel_e         bsel;

   if (PAD_W == 0) begin : g_full
      assign word_r = vis;
      assign word_l = vis;
   end else begin : g_pad
      assign word_r = {{PAD_W{1'b0}}, vis};
      assign word_l = {vis, {PAD_W{1'b0}}};
   end

   assign bsel    = byte_sel_e'(rd_hi);
   assign word    = left_align ? word_l : word_r;
   assign rd_data = (bsel == BYTE_HI) ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];

endmodule

// File: rtl/adc_clkdiv_result.sv
module adc_clkdiv_result #(
   parameter int RES_W   = 10,
   parameter int BYTE_W  = 8,
   parameter int SEL_W   = 3,
   parameter int MIN_EXP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  div_sel,
   input  logic              left_align,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   input  logic              rd_stb,
   input  logic              rd_hi,
   output logic              conv_clk_en,
   output logic [BYTE_W-1:0] rd_data
);

   if (RES_W <= BYTE_W) begin : g_bad_narrow
      $error("adc_clkdiv_result: RES_W must exceed one byte");
   end
   if (RES_W > 2 * BYTE_W) begin : g_bad_wide
      $error("adc_clkdiv_result: RES_W must fit in two bytes");
   end

   logic [RES_W-1:0] vis_q;
   logic             lock_q;

   adcr_clkdiv #(
      .SEL_W   (SEL_W),
      .MIN_EXP (MIN_EXP)
   ) div_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_sel (div_sel),
      .clk_en  (conv_clk_en)
   );

   adcr_result_store #(
      .RES_W (RES_W)
   ) store_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .conv_done   (conv_done),
      .conv_result (conv_result),
      .rd_stb      (rd_stb),
      .rd_hi       (rd_hi),
      .vis_q       (vis_q),
      .lock_q      (lock_q)
   );

   adcr_byte_format #(
      .RES_W  (RES_W),
      .BYTE_W (BYTE_W)
   ) fmt_i (
      .vis        (vis_q),
      .left_align (left_align),
      .rd_hi      (rd_hi),
      .rd_data    (rd_data)
   );

endmodule

// File: rtl/adcr_chk.sv
module adcr_chk #(
   parameter int RES_W = 10,
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SEL_W-1:0] div_sel,
   input logic             conv_clk_en,
   input logic             conv_done,
   input logic [RES_W-1:0] conv_result,
   input logic             rd_stb,
   input logic             rd_hi,
   input logic [RES_W-1:0] vis_q,
   input logic             lock_q
);

   // R2
   en_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_clk_en |=> !conv_clk_en);

   // R3
   sel_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_sel != $past(div_sel)) |-> !conv_clk_en);

   // R7
   low_read_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !rd_hi) |=> lock_q);

   // R7
   hold_while_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !(rd_stb && rd_hi)) |=> $stable(vis_q));

   // R8
   high_read_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_hi) |=> !lock_q);

   // R6
   unlocked_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !lock_q && !(rd_stb && !rd_hi)) |=> (vis_q == $past(conv_result)));

   // R9
   release_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && rd_stb && rd_hi) |=> (vis_q == $past(conv_result)));

endmodule

bind adc_clkdiv_result adcr_chk #(
   .RES_W (RES_W),
   .SEL_W (SEL_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .div_sel     (div_sel),
   .conv_clk_en (conv_clk_en),
   .conv_done   (conv_done),
   .conv_result (conv_result),
   .rd_stb      (rd_stb),
   .rd_hi       (rd_hi),
   .vis_q       (vis_q),
   .lock_q      (lock_q)
);

// File: tb/adc_clkdiv_result_tb_top.sv
module adc_clkdiv_result_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] div_sel = 3'd0;
   logic       left_align = 1'b0;
   logic       conv_done = 1'b0;
   logic [9:0] conv_result = '0;
   logic       rd_stb = 1'b0;
   logic       rd_hi = 1'b0;
   logic       conv_clk_en;
   logic [7:0] rd_data;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   adc_clkdiv_result dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .div_sel     (div_sel),
      .left_align  (left_align),
      .conv_done   (conv_done),
      .conv_result (conv_result),
      .rd_stb      (rd_stb),
      .rd_hi       (rd_hi),
      .conv_clk_en (conv_clk_en),
      .rd_data     (rd_data)
   );

   // {align, result, expected low byte, expected high byte}
   localparam logic [26:0] VEC [8] = '{
      {1'b0, 10'h3FF, 8'hFF, 8'h03},
      {1'b1, 10'h3FF, 8'hC0, 8'hFF},
      {1'b0, 10'h155, 8'h55, 8'h01},
      {1'b1, 10'h155, 8'h40, 8'h55},
      {1'b0, 10'h2A3, 8'hA3, 8'h02},
      {1'b1, 10'h2A3, 8'hC0, 8'hA8},
      {1'b1, 10'h001, 8'h40, 8'h00},
      {1'b0, 10'h200, 8'h00, 8'h02}
   };

   localparam int SEQ [8] = '{3, 0, 7, 1, 2, 4, 5, 6};

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_conv(input logic [9:0] r);
      @(negedge clk);
      conv_done   = 1'b1;
      conv_result = r;
      @(negedge clk);
      conv_done   = 1'b0;
   endtask

   task automatic rd_byte(input logic hi, output logic [7:0] d);
      @(negedge clk);
      rd_stb = 1'b1;
      rd_hi  = hi;
      #1 d = rd_data;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic peek(input logic hi, output logic [7:0] d);
      rd_hi = hi;
      #1 d = rd_data;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         finish_run();
      end
   end

   initial begin
      logic [7:0] d;
      int n;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", {7'd0, conv_clk_en}, 8'h00);
      peek(1'b0, d); chk("R1", d, 8'h00);
      peek(1'b1, d); chk("R1", d, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      peek(1'b0, d); chk("R1", d, 8'h00);
      peek(1'b1, d); chk("R1", d, 8'h00);

      // R4 R5 R6: layouts via the full two-byte protocol
      for (int i = 0; i < 8; i++) begin
         left_align = VEC[i][26];
         do_conv(VEC[i][25:16]);
         rd_byte(1'b1, d); chk(VEC[i][26] ? "R5" : "R4", d, VEC[i][7:0]);
         rd_byte(1'b0, d); chk(VEC[i][26] ? "R5" : "R4", d, VEC[i][15:8]);
         rd_byte(1'b1, d); chk(VEC[i][26] ? "R5" : "R4", d, VEC[i][7:0]);
      end

      // R2 R3: divider periods and restart on select change
      for (int k = 0; k < 8; k++) begin
         int f;
         f = (SEQ[k] < 2) ? 2 : (1 << SEQ[k]);
         @(negedge clk);
         div_sel = 3'(SEQ[k]);
         n = 0;
         do begin
            @(negedge clk);
            n++;
         end while (!conv_clk_en && n < 300);
         chk("R3", 8'(n), 8'(f));
         n = 0;
         do begin
            @(negedge clk);
            n++;
         end while (!conv_clk_en && n < 300);
         chk("R2", 8'(n), 8'(f));
      end

      // R7 R9: lock, deferred conversion, transfer on release
      left_align = 1'b0;
      do_conv(10'h111);
      rd_byte(1'b0, d); chk("R7", d, 8'h11);
      do_conv(10'h2EE);
      peek(1'b1, d); chk("R7", d, 8'h01);
      peek(1'b0, d); chk("R7", d, 8'h11);
      rd_byte(1'b1, d); chk("R7", d, 8'h01);
      peek(1'b0, d); chk("R9", d, 8'hEE);
      peek(1'b1, d); chk("R9", d, 8'h02);

      // R9: newest of several deferred conversions wins
      rd_byte(1'b0, d); chk("R9", d, 8'hEE);
      do_conv(10'h0AA);
      do_conv(10'h355);
      peek(1'b0, d); chk("R7", d, 8'hEE);
      rd_byte(1'b1, d); chk("R9", d, 8'h02);
      peek(1'b0, d); chk("R9", d, 8'h55);
      peek(1'b1, d); chk("R9", d, 8'h03);

      // R8 R6: high-only read leaves the pair unlocked
      left_align = 1'b1;
      rd_byte(1'b1, d); chk("R8", d, 8'hD5);
      do_conv(10'h0F0);
      peek(1'b1, d); chk("R8", d, 8'h3C);
      peek(1'b0, d); chk("R8", d, 8'h00);
      left_align = 1'b0;
      peek(1'b0, d); chk("R6", d, 8'hF0);

      // R11: conversion in the same cycle as the locking low read
      @(negedge clk);
      rd_stb = 1'b1; rd_hi = 1'b0;
      conv_done = 1'b1; conv_result = 10'h123;
      #1 d = rd_data; chk("R11", d, 8'hF0);
      @(negedge clk);
      rd_stb = 1'b0; conv_done = 1'b0;
      peek(1'b1, d); chk("R11", d, 8'h00);
      rd_byte(1'b1, d); chk("R11", d, 8'h00);
      peek(1'b0, d); chk("R11", d, 8'h23);
      peek(1'b1, d); chk("R11", d, 8'h01);

      // R10: alignment applied at read time
      left_align = 1'b1;
      peek(1'b1, d); chk("R10", d, 8'h48);
      peek(1'b0, d); chk("R10", d, 8'hC0);
      left_align = 1'b0;
      peek(1'b1, d); chk("R10", d, 8'h01);

      // R9: conversion in the same cycle as the releasing high read
      rd_byte(1'b0, d); chk("R9", d, 8'h23);
      do_conv(10'h100);
      @(negedge clk);
      rd_stb = 1'b1; rd_hi = 1'b1;
      conv_done = 1'b1; conv_result = 10'h3C3;
      #1 d = rd_data; chk("R9", d, 8'h01);
      @(negedge clk);
      rd_stb = 1'b0; conv_done = 1'b0;
      peek(1'b0, d); chk("R9", d, 8'hC3);
      peek(1'b1, d); chk("R9", d, 8'h03);

      finish_run();
   end

endmodule